// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This block compares two binary floating-point operands of configurable exponent and fraction width. It reports the raw relation between them as less-than, equal, greater-than and unordered, together with a five-bit exception vector. It also reduces the relation to a single result bit chosen by a 4-bit predicate code. The predicates cover ordered and unordered forms of every relation, the two NaN tests, and the two constant answers.

A caller raises `go` with the operands and the predicate code, holds `go` until `done` is seen, and drops it then. For data predicates, an internal comparator engine runs first. The engine is quiet for the equality family and signalling for the inequality family, and the unit picks that mode from the predicate. Once the engine reports, one or two relation bits are captured, each optionally inverted, into 1-bit registers. These are merged by AND or OR, or passed through alone, into the result register. The two constant predicates finish at once and start no comparison.

The control state machine has four states. T_IDLE waits for `go`. T_RUN waits for the engine. T_MERGE writes the result register. T_FIN drives `done` for one cycle. The transitions are: T_IDLE to T_FIN on `go` with a constant predicate; T_IDLE to T_RUN on `go` with a data predicate; T_RUN to T_MERGE when the engine reports; T_MERGE to T_FIN always; and T_FIN to T_IDLE always. The engine has three states, C_IDLE, C_EVAL and C_REPORT. It moves from C_IDLE to C_EVAL on start, from C_EVAL to C_REPORT always, and from C_REPORT back to C_IDLE always.

Top module: `fp_predicate_cmp`

## Requirements
- R1: With the block idle, `go` high at a rising edge starts an operation, and `lhs`, `rhs` and `pred` are sampled only at that edge. For a data predicate, `done` is high during the cycle after the fourth rising edge counted from the start edge and low before it.
- R2: Predicate codes 0 (always false) and 15 (always true) raise `done` after the first edge, with `result` 0 and 1 respectively. `lt`, `eq`, `gt`, `unord` and `flags` keep their previous values.
- R3: The predicate codes are 1 oeq, 2 ogt, 3 oge, 4 olt, 5 ole, 6 one, 7 ord, 8 uno, 9 ueq, 10 ugt, 11 uge, 12 ult, 13 ule and 14 une. An o-prefixed relation is true only when the operands are ordered and the relation holds. A u-prefixed relation is true when the operands are unordered or the relation holds. "one" means ordered and not equal, "une" means unordered or not equal, "ord" means neither operand is NaN, and "uno" means at least one is.
- R4: After a data predicate, exactly one of `lt`, `eq`, `gt`, `unord` is 1. When `unord` is 1, the other three are 0.
- R5: Ordering follows the real values. +0 and -0 are equal, infinities lie beyond every finite value, and subnormals order above zero.
- R6: An operand is NaN when its exponent field is all ones and its fraction is nonzero. A NaN is signalling when the top fraction bit is 0. A NaN on either side sets `unord`.
- R7: `flags` is {invalid, div-by-zero, overflow, underflow, inexact}, and bits 3..0 are always 0. invalid is set when either operand is a signalling NaN. It is also set when either operand is any NaN and the predicate is one of ogt, oge, olt, ole, ugt, uge, ult or ule, which run in signalling mode.
- R8: `done` is high for exactly one cycle per operation, and `result` holds its value until the next operation completes.
- R9: After reset, `done`, `result`, `lt`, `eq`, `gt`, `unord` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, held until done |
| pred | input | 4 | Predicate code |
| lhs | input | EXP_W+FRAC_W+1 | Left operand |
| rhs | input | EXP_W+FRAC_W+1 | Right operand |
| lt | output | 1 | Left less than right |
| eq | output | 1 | Operands equal |
| gt | output | 1 | Left greater than right |
| unord | output | 1 | At least one operand is NaN |
| flags | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |
| result | output | 1 | Registered predicate result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the caller keeps `go` high from the start edge until it has seen `done`. That is what lets every `done` be traced back to a `go` in the previous cycle. The stimulus keeps to this rule by dropping `go` at the falling edge on which `done` is observed. It also scrambles the operand inputs one cycle after the start, so that any late sampling changes the result. Each operand pair is swept through all sixteen codes back to back, so the engine's mode switches between quiet and signalling from one operation to the next.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;

    typedef enum logic [3:0] {
        P_FALSE = 4'd0,  P_OEQ = 4'd1,  P_OGT = 4'd2,  P_OGE = 4'd3,
        P_OLT   = 4'd4,  P_OLE = 4'd5,  P_ONE = 4'd6,  P_ORD = 4'd7,
        P_UNO   = 4'd8,  P_UEQ = 4'd9,  P_UGT = 4'd10, P_UGE = 4'd11,
        P_ULT   = 4'd12, P_ULE = 4'd13, P_UNE = 4'd14, P_TRUE = 4'd15
    } pred_e;

    // index into the relation vector {un, lt, gt, eq}
    typedef enum logic [1:0] {
        REL_EQ = 2'd0, REL_GT = 2'd1, REL_LT = 2'd2, REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        MIX_NONE = 2'd0, MIX_AND = 2'd1, MIX_OR = 2'd2, MIX_CONST = 2'd3
    } mix_e;

    typedef struct packed {
        mix_e mix;
        logic const_val;
        logic signaling;
        rel_e sel0;
        logic inv0;
        rel_e sel1;
        logic inv1;
    } recipe_t;

    function automatic recipe_t decode_pred(input logic [3:0] code);
        recipe_t r;
        r = '{mix: MIX_NONE, const_val: 1'b0, signaling: 1'b0,
              sel0: REL_UN, inv0: 1'b0, sel1: REL_UN, inv1: 1'b1};
        unique case (pred_e'(code))
            P_FALSE: begin r.mix = MIX_CONST; r.const_val = 1'b0; end
            P_TRUE:  begin r.mix = MIX_CONST; r.const_val = 1'b1; end
            P_OEQ:   begin r.mix = MIX_AND; r.sel0 = REL_EQ; end
            P_ONE:   begin r.mix = MIX_AND; r.sel0 = REL_EQ; r.inv0 = 1'b1; end
            P_OGT:   begin r.mix = MIX_AND; r.sel0 = REL_GT; r.signaling = 1'b1; end
            P_OGE:   begin r.mix = MIX_AND; r.sel0 = REL_LT; r.inv0 = 1'b1; r.signaling = 1'b1; end
            P_OLT:   begin r.mix = MIX_AND; r.sel0 = REL_LT; r.signaling = 1'b1; end
            P_OLE:   begin r.mix = MIX_AND; r.sel0 = REL_GT; r.inv0 = 1'b1; r.signaling = 1'b1; end
            P_ORD:   begin r.sel0 = REL_UN; r.inv0 = 1'b1; end
            P_UNO:   begin r.sel0 = REL_UN; end
            P_UEQ:   begin r.mix = MIX_OR; r.sel0 = REL_EQ; r.inv1 = 1'b0; end
            P_UGT:   begin r.mix = MIX_OR; r.sel0 = REL_GT; r.inv1 = 1'b0; r.signaling = 1'b1; end
            P_ULT:   begin r.mix = MIX_OR; r.sel0 = REL_LT; r.inv1 = 1'b0; r.signaling = 1'b1; end
            P_UGE:   begin r.sel0 = REL_LT; r.inv0 = 1'b1; r.signaling = 1'b1; end
            P_ULE:   begin r.sel0 = REL_GT; r.inv0 = 1'b1; r.signaling = 1'b1; end
            P_UNE:   begin r.sel0 = REL_EQ; r.inv0 = 1'b1; end
            default: r.mix = MIX_CONST;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpc_classify.sv
`timescale 1ns/1ps
module fpc_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W-1:0] mag,
    output logic                    is_nan,
    output logic                    is_snan,
    output logic                    is_zero
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo    = mag[EXP_W+FRAC_W-1:FRAC_W];
    assign frac    = mag[FRAC_W-1:0];
    assign is_nan  = (&expo) && (|frac);
    assign is_snan = is_nan && !frac[FRAC_W-1];
    assign is_zero = (mag == '0);
endmodule

// File: rtl/fpc_compare_seq.sv
`timescale 1ns/1ps
module fpc_compare_seq #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    signaling,
    input  logic [EXP_W+FRAC_W:0]   a,
    input  logic [EXP_W+FRAC_W:0]   b,
    output logic                    lt_o,
    output logic                    eq_o,
    output logic                    gt_o,
    output logic                    un_o,
    output logic [4:0]              flags_o,
    output logic                    done_o
);
    localparam int W  = EXP_W + FRAC_W + 1;
    localparam int MW = W - 1;

    typedef enum logic [1:0] {C_IDLE, C_EVAL, C_REPORT} cst_e;
    cst_e cst, cst_nx;

    logic [W-1:0]  opnd_q [2];
    logic          sig_q;
    logic [1:0]    nan_v, snan_v, zero_v;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .mag     (opnd_q[g][MW-1:0]),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g]),
            .is_zero (zero_v[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) cst <= C_IDLE;
        else     cst <= cst_nx;
    end

    always_comb begin
        cst_nx = cst;
        unique case (cst)
            C_IDLE:   if (start) cst_nx = C_EVAL;
            C_EVAL:   cst_nx = C_REPORT;
            C_REPORT: cst_nx = C_IDLE;
            default:  cst_nx = C_IDLE;
        endcase
    end

    // relation of the latched operands
    logic         sa, sb, mag_lt, mag_eq;
    logic         r_lt, r_eq, r_gt, r_un, r_inv;
    always_comb begin
        sa     = opnd_q[0][MW];
        sb     = opnd_q[1][MW];
        mag_lt = opnd_q[0][MW-1:0] < opnd_q[1][MW-1:0];
        mag_eq = opnd_q[0][MW-1:0] == opnd_q[1][MW-1:0];
        r_un   = |nan_v;
        r_lt   = 1'b0;
        r_eq   = 1'b0;
        r_gt   = 1'b0;
        if (!r_un) begin
            if (&zero_v)       r_eq = 1'b1;
            else if (sa != sb) begin r_lt = sa; r_gt = sb; end
            else if (mag_eq)   r_eq = 1'b1;
            else if (!sa)      begin r_lt = mag_lt;  r_gt = !mag_lt; end
            else               begin r_lt = !mag_lt; r_gt = mag_lt;  end
        end
        r_inv = (|snan_v) || (sig_q && r_un);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q[0] <= '0;
            opnd_q[1] <= '0;
            sig_q     <= 1'b0;
            lt_o      <= 1'b0;
            eq_o      <= 1'b0;
            gt_o      <= 1'b0;
            un_o      <= 1'b0;
            flags_o   <= '0;
        end else begin
            if (cst == C_IDLE && start) begin
                opnd_q[0] <= a;
                opnd_q[1] <= b;
                sig_q     <= signaling;
            end
            if (cst == C_EVAL) begin
                lt_o    <= r_lt;
                eq_o    <= r_eq;
                gt_o    <= r_gt;
                un_o    <= r_un;
                flags_o <= {r_inv, 4'b0000};
            end
        end
    end

    assign done_o = (cst == C_REPORT);
endmodule

// File: rtl/fpc_bit_slot.sv
`timescale 1ns/1ps
module fpc_bit_slot
    import fpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  rel_e       sel,
    input  logic       inv,
    input  logic [3:0] rel_bits,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (we) q <= rel_bits[sel] ^ inv;
    end
endmodule

// File: rtl/fp_predicate_cmp.sv
`timescale 1ns/1ps
module fp_predicate_cmp
    import fpc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [3:0]            pred,
    input  logic [EXP_W+FRAC_W:0] lhs,
    input  logic [EXP_W+FRAC_W:0] rhs,
    output logic                  lt,
    output logic                  eq,
    output logic                  gt,
    output logic                  unord,
    output logic [4:0]            flags,
    output logic                  result,
    output logic                  done
);
    localparam int SLOTS = 2;

    typedef enum logic [1:0] {T_IDLE, T_RUN, T_MERGE, T_FIN} tst_e;
    tst_e st, st_nx;

    recipe_t rec_in;
    assign rec_in = decode_pred(pred);

    mix_e        mix_q;
    rel_e        sel_q [SLOTS];
    logic        inv_q [SLOTS];
    logic [SLOTS-1:0] slot_q;
    logic        core_start, core_done, slot_we;
    logic        result_q;

    fpc_compare_seq #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_core (
        .clk       (clk),
        .rst       (rst),
        .start     (core_start),
        .signaling (rec_in.signaling),
        .a         (lhs),
        .b         (rhs),
        .lt_o      (lt),
        .eq_o      (eq),
        .gt_o      (gt),
        .un_o      (unord),
        .flags_o   (flags),
        .done_o    (core_done)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic we_s;
        if (s == 0) begin : g_first
            assign we_s = slot_we;
        end else begin : g_pair
            assign we_s = slot_we && (mix_q != MIX_NONE);
        end
        fpc_bit_slot i_slot (
            .clk      (clk),
            .rst      (rst),
            .we       (we_s),
            .sel      (sel_q[s]),
            .inv      (inv_q[s]),
            .rel_bits ({unord, lt, gt, eq}),
            .q        (slot_q[s])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= T_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            T_IDLE:  if (go) st_nx = (rec_in.mix == MIX_CONST) ? T_FIN : T_RUN;
            T_RUN:   if (core_done) st_nx = T_MERGE;
            T_MERGE: st_nx = T_FIN;
            T_FIN:   st_nx = T_IDLE;
            default: st_nx = T_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        core_start = (st == T_IDLE) && go && (rec_in.mix != MIX_CONST);
        slot_we    = (st == T_RUN) && core_done;
        done       = (st == T_FIN);
    end

    // recipe capture and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q    <= MIX_NONE;
            sel_q[0] <= REL_EQ;
            sel_q[1] <= REL_EQ;
            inv_q[0] <= 1'b0;
            inv_q[1] <= 1'b0;
            result_q <= 1'b0;
        end else begin
            if (st == T_IDLE && go) begin
                mix_q    <= rec_in.mix;
                sel_q[0] <= rec_in.sel0;
                sel_q[1] <= rec_in.sel1;
                inv_q[0] <= rec_in.inv0;
                inv_q[1] <= rec_in.inv1;
                if (rec_in.mix == MIX_CONST) result_q <= rec_in.const_val;
            end
            if (st == T_MERGE) begin
                unique case (mix_q)
                    MIX_AND: result_q <= &slot_q;
                    MIX_OR:  result_q <= |slot_q;
                    default: result_q <= slot_q[0];
                endcase
            end
        end
    end

    assign result = result_q;
endmodule

// File: rtl/fpc_checker.sv
`timescale 1ns/1ps
module fpc_checker (
    input logic       clk,
    input logic       rst,
    input logic       go,
    input logic       lt,
    input logic       eq,
    input logic       gt,
    input logic       unord,
    input logic [4:0] flags,
    input logic       done
);
    // R4: relation bits never overlap
    a_r4_relation_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lt, eq, gt, unord}));

    // R7: only the invalid bit may ever be raised
    a_r7_low_flags_zero: assert property (@(posedge clk) disable iff (rst)
        flags[3:0] == 4'b0000);

    // R7: invalid needs a NaN operand
    a_r7_invalid_needs_nan: assert property (@(posedge clk) disable iff (rst)
        flags[4] |-> unord);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: completion only follows a held request
    a_r1_done_after_go: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(go));
endmodule

bind fp_predicate_cmp fpc_checker i_fpc_checker (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .lt    (lt),
    .eq    (eq),
    .gt    (gt),
    .unord (unord),
    .flags (flags),
    .done  (done)
);

// File: tb/test_fp_predicate_cmp.sv
`timescale 1ns/1ps
module test_fp_predicate_cmp;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int W      = EXP_W + FRAC_W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go  = 1'b0;
    logic [3:0]   pred = '0;
    logic [W-1:0] lhs = '0, rhs = '0;
    logic         lt, eq, gt, unord, result, done;
    logic [4:0]   flags;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_predicate_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fp_predicate_cmp (
        .clk(clk), .rst(rst), .go(go), .pred(pred), .lhs(lhs), .rhs(rhs),
        .lt(lt), .eq(eq), .gt(gt), .unord(unord), .flags(flags),
        .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    function automatic bit is_nan(input logic [W-1:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [W-1:0] x);
        return is_nan(x) && (x[22] == 1'b0);
    endfunction
    function automatic longint value_key(input logic [W-1:0] x);
        longint m;
        m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction
    function automatic bit pred_truth(input int p, input bit u, input bit l, input bit e, input bit g);
        case (p)
            0:  return 1'b0;
            1:  return !u && e;
            2:  return !u && g;
            3:  return !u && (g || e);
            4:  return !u && l;
            5:  return !u && (l || e);
            6:  return !u && !e;
            7:  return !u;
            8:  return u;
            9:  return u || e;
            10: return u || g;
            11: return u || g || e;
            12: return u || l;
            13: return u || l || e;
            14: return u || !e;
            default: return 1'b1;
        endcase
    endfunction

    // last relation seen by the model, used when constant predicates run
    logic [3:0] prev_rel = 4'b0000;
    logic [4:0] prev_flags = 5'b0;

    task automatic run(input int p, input logic [W-1:0] a, input logic [W-1:0] b);
        bit u, l, e, g, res, sigcls, inv, is_const, finished;
        int lat;
        logic [3:0] exp_rel;
        logic [4:0] exp_flags;
        u = is_nan(a) || is_nan(b);
        l = !u && (value_key(a) < value_key(b));
        e = !u && (value_key(a) == value_key(b));
        g = !u && (value_key(a) > value_key(b));
        res = pred_truth(p, u, l, e, g);
        sigcls = (p >= 2 && p <= 5) || (p >= 10 && p <= 13);
        inv = is_snan(a) || is_snan(b) || (sigcls && u);
        is_const = (p == 0) || (p == 15);
        lat = is_const ? 1 : 4;
        exp_rel   = is_const ? prev_rel : {u, l, e, g};
        exp_flags = is_const ? prev_flags : {inv, 4'b0000};
        finished = 1'b0;

        @(negedge clk);
        pred = 4'(p); lhs = a; rhs = b; go = 1'b1;
        for (int n = 1; n <= 8 && !finished; n++) begin
            @(negedge clk);
            if (n == 1) begin
                lhs = ~a; rhs = a ^ 32'h0055_1234; pred = ~4'(p);
            end
            chk(done == (n == lat), $sformatf("R1 done timing p=%0d cycle %0d", p, n), done, (n == lat));
            if (done) begin
                go = 1'b0;
                finished = 1'b1;
                chk(result == res, $sformatf("R3 result p=%0d a=%h b=%h", p, a, b), result, res);
                chk({unord, lt, eq, gt} == exp_rel,
                    $sformatf("%s relation p=%0d a=%h b=%h", is_const ? "R2" : "R4 R5 R6", p, a, b),
                    {unord, lt, eq, gt}, exp_rel);
                chk(flags == exp_flags,
                    $sformatf("%s flags p=%0d a=%h b=%h", is_const ? "R2" : "R7", p, a, b),
                    flags, exp_flags);
            end
        end
        if (!finished) chk(1'b0, $sformatf("R1 no done p=%0d", p), 0, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done drops", done, 0);
        chk(result == res, "R8 result held", result, res);
        prev_rel = exp_rel;
        prev_flags = exp_flags;
    endtask

    logic [W-1:0] va [12];
    logic [W-1:0] vb [12];

    initial begin
        va[0]  = 32'h3F80_0000; vb[0]  = 32'h4000_0000; // 1 vs 2
        va[1]  = 32'h4000_0000; vb[1]  = 32'h3F80_0000; // 2 vs 1
        va[2]  = 32'h3F80_0000; vb[2]  = 32'h3F80_0000; // equal
        va[3]  = 32'h0000_0000; vb[3]  = 32'h8000_0000; // +0 vs -0 (R5)
        va[4]  = 32'hBF80_0000; vb[4]  = 32'hC000_0000; // -1 vs -2
        va[5]  = 32'hC040_0000; vb[5]  = 32'h40A0_0000; // -3 vs 5
        va[6]  = 32'h7FC0_0000; vb[6]  = 32'h3F80_0000; // quiet NaN (R6)
        va[7]  = 32'h3F80_0000; vb[7]  = 32'h7F80_0001; // signalling NaN (R6 R7)
        va[8]  = 32'h7F80_0000; vb[8]  = 32'h7F7F_FFFF; // +inf vs max
        va[9]  = 32'hFF80_0000; vb[9]  = 32'h0000_0001; // -inf vs subnormal
        va[10] = 32'h0000_0001; vb[10] = 32'h0000_0000; // subnormal vs +0
        va[11] = 32'h7FC0_0000; vb[11] = 32'hFFC0_0001; // two quiet NaNs

        repeat (3) @(negedge clk);
        // R9 reset state
        chk({done, result, lt, eq, gt, unord} == 6'b0, "R9 reset outputs", {done, result, lt, eq, gt, unord}, 0);
        chk(flags == 5'b0, "R9 reset flags", flags, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9 idle after reset", done, 0);

        for (int k = 0; k < 12; k++)
            for (int p = 0; p < 16; p++)
                run(p, va[k], vb[k]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule